// File: doc/BRIEF.md
# Registered AND-OR Logic Array

This block is a synthesizable model of a small fuse-configured logic array with registered outputs. A configuration store keeps one bit per crossing of the array's input lines and product-term lines, plus one polarity bit per output. A stored 1 means the fuse is intact, so the line is connected. After reset every fuse is intact, which is the blank state: every product term is held low and every output register stays low.

Sixteen array inputs feed the AND plane in true and complement form. Twelve are dedicated inputs. Four come from the output pins, and each of those is the wired-OR of the output register and an external drive. The 32 product terms are split into four groups of eight. Each group is ORed, inverted or passed through according to its polarity bit, and loaded into that output's register. Output pins 0 and 1 load on a rising edge of strobe A OR the common strobe. Pins 2 and 3 load on a rising edge of strobe B OR the common strobe. All strobes are sampled with the system clock, so no clock is gated. An asynchronous master reset clears all four registers.

A pin whose function is left blank keeps its register low, so its external drive acts as an extra input. The block is configured through a one-bit-per-cycle write port and then used as a small sequential logic element.

Top module: `sop_reg_array`

## Requirements
- R1: After rst_n is released, every array and polarity fuse is intact (1) and q is 0. q stays 0 on any strobe, whatever din and io_ext are.
- R2: A write with cfg_we stores cfg_bit (1 intact, 0 blown) into cell cfg_addr = 32*p + line. Here p is the product term and line 2k / 2k+1 is the true / complement form of array input k.
- R3: A product term is 1 exactly when every input line still connected to it is 1. A term with all fuses blown is 1.
- R4: A product term that keeps both the true and the complement line of any one array input is 0.
- R5: The sum of output g is the OR of product terms 8g to 8g+7.
- R6: Polarity bit g (pol_sel = g), when intact (1), loads the sum into register g. When blown (0), it loads the inverted sum. q always shows the register value.
- R7: Registers q[0] and q[1] load in the clk cycle in which (strobe_a | strobe_com) is first seen high. The other registers are unaffected.
- R8: Registers q[2] and q[3] load in the clk cycle in which (strobe_b | strobe_com) is first seen high. The other registers are unaffected.
- R9: A strobe level held high causes no further loads. A second strobe rising while its pair's OR is already high causes no load.
- R10: While mreset is high, q is 0 at once without waiting for clk, and strobes have no effect.
- R11: Array input 12+i is q[i] OR io_ext[i]. An output with all-intact fuses stays 0, so io_ext[i] alone drives that array input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; restores every fuse to intact and clears the registers |
| cfg_we | input | 1 | Array fuse write strobe |
| cfg_addr | input | 10 | Array fuse cell index, 32*term + line |
| cfg_bit | input | 1 | Fuse value written, 1 intact, 0 blown |
| pol_we | input | 1 | Polarity fuse write strobe |
| pol_sel | input | 2 | Output whose polarity fuse is written |
| pol_bit | input | 1 | Polarity value, 1 intact (active-high), 0 blown (inverted) |
| din | input | 12 | Dedicated array inputs 0 to 11 |
| io_ext | input | 4 | External drive on the output pins, ORed with the registers |
| strobe_a | input | 1 | Load strobe for outputs 0 and 1 |
| strobe_b | input | 1 | Load strobe for outputs 2 and 3 |
| strobe_com | input | 1 | Load strobe shared by all outputs |
| mreset | input | 1 | Asynchronous master reset of the output registers |
| q | output | 4 | Output register values |

## Verification
On every cycle, the assertions check four things. A fuse write lands in the addressed cell. Any term that holds a complementary pair of lines stays low. Each register pair loads the array result on its own sampled edge and holds otherwise. A load enable never lasts two cycles, and master reset keeps all registers clear. Only the bench's scenarios can show the array's logical function with the feedback path in use, which takes a programmed fuse pattern and a sequence of loads. The same holds for the independence of the two register pairs, the all-blown term and the wired-OR external input.

// File: rtl/sra_pkg.sv
`timescale 1ns/1ps
package sra_pkg;
  localparam int DEF_DED       = 12;
  localparam int DEF_IO        = 4;
  localparam int DEF_TERMS_OUT = 8;

  // line numbering of array input k: even = true form, odd = complement
  function automatic int true_line(input int k);
    return 2 * k;
  endfunction

  function automatic int comp_line(input int k);
    return 2 * k + 1;
  endfunction

  // one product term: connected lines must all be high
  function automatic logic term_true(input logic [63:0] row, input logic [63:0] lines,
                                     input int n_line);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n_line; i++) begin
      if (row[i] && !lines[i]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/sra_fuse_store.sv
`timescale 1ns/1ps
module sra_fuse_store #(
  parameter int N_CELL = 1024,
  parameter int N_OUT  = 4,
  localparam int ADDR_W = $clog2(N_CELL),
  localparam int SEL_W  = $clog2(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_bit,
  input  logic              pol_we,
  input  logic [SEL_W-1:0]  pol_sel,
  input  logic              pol_bit,
  output logic [N_CELL-1:0] array_fuse,
  output logic [N_OUT-1:0]  pol_fuse
);
  logic [N_CELL-1:0] cell_q;
  logic [N_OUT-1:0]  pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '1;
      pol_q  <= '1;
    end else begin
      if (cfg_we) cell_q[cfg_addr] <= cfg_bit;
      if (pol_we) pol_q[pol_sel]   <= pol_bit;
    end
  end

  assign array_fuse = cell_q;
  assign pol_fuse   = pol_q;

  // R2: addressed cell takes the written value
  p_cell_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (array_fuse[$past(cfg_addr)] == $past(cfg_bit)));

  // R6: polarity write lands in the selected output
  p_pol_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pol_we |=> (pol_fuse[$past(pol_sel)] == $past(pol_bit)));
endmodule

// File: rtl/sra_and_plane.sv
`timescale 1ns/1ps
module sra_and_plane #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 32,
  localparam int N_LINE = 2 * N_IN,
  localparam int N_CELL = N_TERM * N_LINE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   ain,
  input  logic [N_CELL-1:0] array_fuse,
  output logic [N_TERM-1:0] term
);
  logic [N_LINE-1:0] lines;

  always_comb begin
    lines = '0;
    for (int k = 0; k < N_IN; k++) begin
      lines[sra_pkg::true_line(k)] = ain[k];
      lines[sra_pkg::comp_line(k)] = ~ain[k];
    end
  end

  for (genvar p = 0; p < N_TERM; p++) begin : g_term
    logic [N_LINE-1:0] row;
    logic [63:0]       row_w;
    logic [63:0]       line_w;
    logic              pair_kept;

    assign row    = array_fuse[p*N_LINE +: N_LINE];
    assign row_w  = 64'(row);
    assign line_w = 64'(lines);
    assign term[p] = sra_pkg::term_true(row_w, line_w, N_LINE);

    always_comb begin
      pair_kept = 1'b0;
      for (int k = 0; k < N_IN; k++) begin
        if (row[2*k] && row[2*k+1]) pair_kept = 1'b1;
      end
    end

    // R4: a term holding both phases of one input is forced low
    p_pair_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pair_kept |-> !term[p]);
  end
endmodule

// File: rtl/sra_or_polarity.sv
`timescale 1ns/1ps
module sra_or_polarity #(
  parameter int N_OUT     = 4,
  parameter int TERMS_OUT = 8,
  localparam int N_TERM = N_OUT * TERMS_OUT
) (
  input  logic [N_TERM-1:0] term,
  input  logic [N_OUT-1:0]  pol_fuse,
  output logic [N_OUT-1:0]  sum,
  output logic [N_OUT-1:0]  next_d
);
  function automatic logic apply_pol(input logic s, input logic intact);
    return intact ? s : ~s;
  endfunction

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign sum[g]    = |term[g*TERMS_OUT +: TERMS_OUT];
    assign next_d[g] = apply_pol(sum[g], pol_fuse[g]);
  end
endmodule

// File: rtl/sra_out_regs.sv
`timescale 1ns/1ps
module sra_out_regs #(
  parameter int N_OUT = 4,
  localparam int HALF = N_OUT / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset,
  input  logic             strobe_a,
  input  logic             strobe_b,
  input  logic             strobe_com,
  input  logic [N_OUT-1:0] next_d,
  output logic [N_OUT-1:0] q,
  output logic             load_a,
  output logic             load_b
);
  logic             lvl_a, lvl_b;
  logic [1:0]       lvl_prev;
  logic [N_OUT-1:0] ld;
  logic [N_OUT-1:0] q_r;

  assign lvl_a = strobe_a | strobe_com;
  assign lvl_b = strobe_b | strobe_com;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 2'b00;
    else        lvl_prev <= {lvl_b, lvl_a};
  end

  assign load_a = lvl_a & ~lvl_prev[0];
  assign load_b = lvl_b & ~lvl_prev[1];

  for (genvar i = 0; i < N_OUT; i++) begin : g_ld
    if (i < HALF) begin : g_pa
      assign ld[i] = load_a;
    end else begin : g_pb
      assign ld[i] = load_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge mreset) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (mreset) begin
      q_r <= '0;
    end else begin
      for (int i = 0; i < N_OUT; i++) begin
        if (ld[i]) q_r[i] <= next_d[i];
      end
    end
  end

  assign q = q_r;

  // R9: a load enable lasts a single cycle
  p_one_shot_a_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_a |=> !load_a);
  p_one_shot_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |=> !load_b);

  // R7: first pair loads on its edge, holds otherwise
  p_pair_a_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a && !mreset) |=> (mreset || q[HALF-1:0] == $past(next_d[HALF-1:0])));
  p_pair_a_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_a && !mreset) |=> (mreset || q[HALF-1:0] == $past(q[HALF-1:0])));

  // R8: second pair loads on its edge, holds otherwise
  p_pair_b_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_b && !mreset) |=> (mreset || q[N_OUT-1:HALF] == $past(next_d[N_OUT-1:HALF])));
  p_pair_b_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_b && !mreset) |=> (mreset || q[N_OUT-1:HALF] == $past(q[N_OUT-1:HALF])));

  // R10: master reset keeps every register clear
  p_mreset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |-> (q == '0));
endmodule

// File: rtl/sop_reg_array.sv
`timescale 1ns/1ps
module sop_reg_array #(
  parameter int N_DED     = sra_pkg::DEF_DED,
  parameter int N_IO      = sra_pkg::DEF_IO,
  parameter int TERMS_OUT = sra_pkg::DEF_TERMS_OUT,
  localparam int N_IN   = N_DED + N_IO,
  localparam int N_OUT  = N_IO,
  localparam int N_TERM = N_OUT * TERMS_OUT,
  localparam int N_LINE = 2 * N_IN,
  localparam int N_CELL = N_TERM * N_LINE,
  localparam int ADDR_W = $clog2(N_CELL),
  localparam int SEL_W  = $clog2(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_bit,
  input  logic              pol_we,
  input  logic [SEL_W-1:0]  pol_sel,
  input  logic              pol_bit,
  input  logic [N_DED-1:0]  din,
  input  logic [N_IO-1:0]   io_ext,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              strobe_com,
  input  logic              mreset,
  output logic [N_OUT-1:0]  q
);
  logic [N_CELL-1:0] array_fuse;
  logic [N_OUT-1:0]  pol_fuse;
  logic [N_IN-1:0]   ain;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;
  logic [N_OUT-1:0]  next_d;
  logic [N_OUT-1:0]  q_int;
  logic              load_a, load_b;

  // pins feed back as wired-OR with any external drive
  assign ain = {q_int | io_ext, din};
  assign q   = q_int;

  sra_fuse_store #(.N_CELL(N_CELL), .N_OUT(N_OUT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_bit(cfg_bit),
    .pol_we(pol_we), .pol_sel(pol_sel), .pol_bit(pol_bit),
    .array_fuse(array_fuse), .pol_fuse(pol_fuse)
  );

  sra_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_plane (
    .clk(clk), .rst_n(rst_n), .ain(ain), .array_fuse(array_fuse), .term(term)
  );

  sra_or_polarity #(.N_OUT(N_OUT), .TERMS_OUT(TERMS_OUT)) u_or (
    .term(term), .pol_fuse(pol_fuse), .sum(sum), .next_d(next_d)
  );

  sra_out_regs #(.N_OUT(N_OUT)) u_regs (
    .clk(clk), .rst_n(rst_n), .mreset(mreset),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .strobe_com(strobe_com),
    .next_d(next_d), .q(q_int), .load_a(load_a), .load_b(load_b)
  );

  // R11: a blank-polarity output with an empty sum never rises on a load
  p_blank_stays_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sum == '0 && pol_fuse == '1 && (load_a || load_b)) |=> (q_int & $past({{(N_OUT/2){load_b}}, {(N_OUT/2){load_a}}})) == '0);
endmodule

// File: tb/tb_sop_reg_array.sv
`timescale 1ns/1ps
module tb_sop_reg_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic        cfg_bit = 1'b0;
  logic        pol_we = 1'b0;
  logic [1:0]  pol_sel = '0;
  logic        pol_bit = 1'b0;
  logic [11:0] din = '0;
  logic [3:0]  io_ext = '0;
  logic        strobe_a = 1'b0, strobe_b = 1'b0, strobe_com = 1'b0;
  logic        mreset = 1'b0;
  logic [3:0]  q;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sop_reg_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_bit(cfg_bit),
    .pol_we(pol_we), .pol_sel(pol_sel), .pol_bit(pol_bit), .din(din), .io_ext(io_ext),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .strobe_com(strobe_com),
    .mreset(mreset), .q(q)
  );

  // stimulus {din, io_ext, expected q} after one common-strobe load
  localparam logic [19:0] VEC [0:7] = '{
    {12'h003, 4'h0, 4'h1},
    {12'h000, 4'h0, 4'h4},
    {12'h004, 4'h0, 4'h2},
    {12'h01C, 4'h0, 4'h4},
    {12'h030, 4'h8, 4'h4},
    {12'h030, 4'h0, 4'h0},
    {12'h001, 4'h1, 4'h4},
    {12'h007, 4'h0, 4'h3}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_cell(input int p, input int line, input logic b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 10'(p * 32 + line); cfg_bit = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_pol(input int g, input logic b);
    @(negedge clk);
    pol_we = 1'b1; pol_sel = 2'(g); pol_bit = b;
    @(negedge clk);
    pol_we = 1'b0;
  endtask

  task automatic blow_row(input int p);
    for (int l = 0; l < 32; l++) write_cell(p, l, 1'b0);
  endtask

  // strobe high across one edge, then low; returns at a falling edge
  task automatic pulse(input logic a, input logic b, input logic c);
    @(negedge clk);
    strobe_a = a; strobe_b = b; strobe_com = c;
    @(negedge clk);
    strobe_a = 1'b0; strobe_b = 1'b0; strobe_com = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state", q, 4'h0);

    // R1: blank array ignores all inputs
    din = 12'hFFF; io_ext = 4'hF;
    pulse(1'b0, 1'b0, 1'b1);
    chk("R1 blank array all inputs high", q, 4'h0);
    din = 12'h555; io_ext = 4'h0;
    pulse(1'b1, 1'b1, 1'b0);
    chk("R1 blank array pattern", q, 4'h0);

    // R2: program through cell = 32*term + line
    blow_row(0);  write_cell(0, 0, 1'b1);  write_cell(0, 2, 1'b1);   // din0 & din1
    blow_row(8);  write_cell(8, 5, 1'b1);                            // ~din2
    blow_row(9);  write_cell(9, 6, 1'b1);                            // din3
    write_pol(1, 1'b0);                                              // invert output 1
    blow_row(16); write_cell(16, 24, 1'b1);                          // input 12
    blow_row(17); write_cell(17, 8, 1'b1); write_cell(17, 11, 1'b1); // din4 & ~din5
    blow_row(18); write_cell(18, 30, 1'b1);                          // input 15

    // R2 R3 R5 R6 R11: table walk with common strobe
    for (int v = 0; v < 8; v++) begin
      din = VEC[v][19:8]; io_ext = VEC[v][7:4];
      pulse(1'b0, 1'b0, 1'b1);
      chk($sformatf("R3 R5 R6 R11 vector %0d", v), q, VEC[v][3:0]);
    end
    io_ext = 4'h0;

    // R8: strobe B loads only outputs 2,3 (q2 takes fed-back q0=1)
    din = 12'h000;
    pulse(1'b0, 1'b1, 1'b0);
    chk("R8 pair B only", q, 4'h7);
    // R7: strobe A loads only outputs 0,1
    pulse(1'b1, 1'b0, 1'b0);
    chk("R7 pair A only", q, 4'h4);

    // R9: held strobe loads once
    @(negedge clk);
    din = 12'h003; strobe_com = 1'b1;
    @(negedge clk);
    chk("R9 first edge loads", q, 4'h1);
    din = 12'h000;
    repeat (3) @(negedge clk);
    chk("R9 held level no reload", q, 4'h1);
    strobe_a = 1'b1; strobe_b = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 second strobe under common no load", q, 4'h1);
    strobe_a = 1'b0; strobe_b = 1'b0; strobe_com = 1'b0;
    @(negedge clk);

    // R10: asynchronous master reset
    #1 mreset = 1'b1;
    #0.5;
    chk("R10 immediate clear", q, 4'h0);
    din = 12'h003;
    pulse(1'b0, 1'b0, 1'b1);
    chk("R10 strobe ignored during reset", q, 4'h0);
    mreset = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 stays clear after release", q, 4'h0);
    pulse(1'b0, 1'b0, 1'b1);
    chk("R10 loads again after release", q, 4'h1);

    // R6: restore active-high on output 1
    write_pol(1, 1'b1);
    din = 12'h000;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R6 active-high output 1", q, 4'h2);

    // R4: re-connect complement of din0 on term 0 alongside true phase
    write_cell(0, 1, 1'b1);
    din = 12'h003;
    pulse(1'b1, 1'b0, 1'b0);
    chk("R4 complementary pair forces term low", q & 4'h1, 4'h0);

    // R3 R11: all-blown term on output 3 is always true
    blow_row(24);
    pulse(1'b0, 1'b1, 1'b0);
    chk("R3 all-blown term true", q & 4'h8, 4'h8);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule